// File: doc/BRIEF.md
# Presence-Tagged Write-Once Memory

This block is a small on-chip store in which every word carries a presence bit. It lets producers and consumers meet on data availability. Each word starts out empty and is written exactly once. A read that finds its word already holding data is answered on the next cycle. A read that finds its word empty is not refused. Its requester tag is parked on a list attached to that word, and the write that later fills the word answers every parked requester automatically.

Parked requests live in a shared pool of linked-list nodes of fixed depth. Each word keeps a head pointer and a tail pointer into that pool. Answers leave through one response port with a valid/ready handshake, so a slow consumer holds the response in place. While a word's waiters are being answered, no new request or write is taken. Writes take priority over reads in the same cycle. A synchronous clear empties every word and the whole pool.

Top module: `pt_presence_mem`

## Requirements
- R1: After reset or a one-cycle `clr`, every word is empty, no request is parked, `rsp_valid` is low, and a read of a word written before the clear produces no response.
- R2: A write accepted on an empty word stores `wr_data` and marks the word present; a later read of that word returns exactly that value.
- R3: A read accepted on an empty word produces no response until that word is written.
- R4: A read accepted on a present word raises `rsp_valid` on the following cycle, with `rsp_tag` equal to the request tag and `rsp_data` equal to the stored word.
- R5: A write accepted on a present word sets `wr_dup_err` high for exactly the following cycle and leaves the stored value unchanged.
- R6: A write that fills a word with parked requests answers each of them exactly once, in the order they were accepted, one per cycle while `rsp_ready` is high; `wr_ready` and `rd_ready` stay low until the last one is issued.
- R7: When `POOL_DEPTH` requests are parked, `rd_ready` is low; it returns high once the parked requests have been answered.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_tag` and `rsp_data` hold their values.
- R9: Parked lists are kept per word: filling one word answers none of the requests parked on another word.
- R10: In any cycle where `wr_valid` is high, `rd_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of all words and the pool |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write accepted this cycle when valid |
| wr_addr | input | ADDR_W | Word address for the write |
| wr_data | input | DATA_W | Value to store |
| wr_dup_err | output | 1 | Pulses one cycle after a write to a present word |
| rd_valid | input | 1 | Read request present |
| rd_ready | output | 1 | Read accepted this cycle when valid |
| rd_addr | input | ADDR_W | Word address for the read |
| rd_tag | input | TAG_W | Requester tag returned with the answer |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_tag | output | TAG_W | Tag of the answered request |
| rsp_data | output | DATA_W | Value of the word |

## Verification
The hardest state to reach is a full pool, with requests from several requesters chained on one word and other words holding lists of their own. The stimulus first parks requests on two words and fills them in the opposite order, to check ordering and isolation between lists. After a clear it parks `POOL_DEPTH` requests on a single word. Then a further read is presented to confirm the backpressure, and the word is written to drain the whole chain back to back.

// File: rtl/pt_mem_pkg.sv
package pt_mem_pkg;

    localparam int unsigned DEF_ADDR_W     = 4;
    localparam int unsigned DEF_DATA_W     = 16;
    localparam int unsigned DEF_TAG_W      = 4;
    localparam int unsigned DEF_POOL_DEPTH = 8;

    typedef enum logic [1:0] {
        WR_NONE,
        WR_FILL,
        WR_WAKE,
        WR_DUP
    } wr_kind_e;

    typedef enum logic [1:0] {
        RD_NONE,
        RD_HIT,
        RD_PARK
    } rd_kind_e;

    function automatic wr_kind_e classify_write(logic fire, logic present, logic waiting);
        if (!fire)        return WR_NONE;
        else if (present) return WR_DUP;
        else if (waiting) return WR_WAKE;
        else              return WR_FILL;
    endfunction

    function automatic rd_kind_e classify_read(logic fire, logic present);
        if (!fire)        return RD_NONE;
        else if (present) return RD_HIT;
        else              return RD_PARK;
    endfunction

endpackage

// File: rtl/pt_word_table.sv
module pt_word_table #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned PTR_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              app_en,
    input  logic [ADDR_W-1:0] app_addr,
    input  logic [PTR_W-1:0]  app_node,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              rd_present,
    output logic [DATA_W-1:0] rd_value,
    output logic              rd_waiting,
    output logic [PTR_W-1:0]  rd_tail,
    output logic              wr_present,
    output logic              wr_waiting,
    output logic [PTR_W-1:0]  wr_head,
    output logic [PTR_W-1:0]  wr_tail
);
    localparam int unsigned WORDS = 1 << ADDR_W;

    logic [WORDS-1:0]  present_q;
    logic [WORDS-1:0]  waiting_q;
    logic [DATA_W-1:0] mem_q  [WORDS];
    logic [PTR_W-1:0]  head_q [WORDS];
    logic [PTR_W-1:0]  tail_q [WORDS];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            present_q <= '0;
            waiting_q <= '0;
        end else begin
            if (fill_en) begin
                present_q[fill_addr] <= 1'b1;
                waiting_q[fill_addr] <= 1'b0;
                mem_q[fill_addr]     <= fill_data;
            end
            if (app_en) begin
                if (!waiting_q[app_addr]) begin
                    head_q[app_addr]    <= app_node;
                    waiting_q[app_addr] <= 1'b1;
                end
                tail_q[app_addr] <= app_node;
            end
        end
    end

    assign rd_present = present_q[rd_addr];
    assign rd_value   = mem_q[rd_addr];
    assign rd_waiting = waiting_q[rd_addr];
    assign rd_tail    = tail_q[rd_addr];
    assign wr_present = present_q[wr_addr];
    assign wr_waiting = waiting_q[wr_addr];
    assign wr_head    = head_q[wr_addr];
    assign wr_tail    = tail_q[wr_addr];

    AST_PRESENT_STICKY: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((present_q & $past(present_q)) == $past(present_q))); // R2

    for (genvar w = 0; w < WORDS; w++) begin : g_frozen
        AST_WORD_FROZEN: assert property (@(posedge clk) disable iff (rst)
            (present_q[w] && !clr) |=> $stable(mem_q[w])); // R5
    end

endmodule

// File: rtl/pt_defer_pool.sv
module pt_defer_pool #(
    parameter int unsigned TAG_W = 4,
    parameter int unsigned DEPTH = 8,
    parameter int unsigned PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             alloc_en,
    input  logic [TAG_W-1:0] alloc_tag,
    output logic [PTR_W-1:0] alloc_idx,
    output logic             pool_full,
    input  logic             link_en,
    input  logic [PTR_W-1:0] link_prev,
    input  logic             free_en,
    input  logic [PTR_W-1:0] free_idx,
    input  logic [PTR_W-1:0] look_idx,
    output logic [TAG_W-1:0] look_tag,
    output logic [PTR_W-1:0] look_next
);
    logic [DEPTH-1:0] used_q;
    logic [TAG_W-1:0] tag_q  [DEPTH];
    logic [PTR_W-1:0] next_q [DEPTH];

    always_comb begin
        alloc_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!used_q[i]) alloc_idx = PTR_W'(i);
        end
    end

    assign pool_full = &used_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            used_q <= '0;
        end else begin
            if (alloc_en) begin
                used_q[alloc_idx] <= 1'b1;
                tag_q[alloc_idx]  <= alloc_tag;
            end
            if (link_en) begin
                next_q[link_prev] <= alloc_idx;
            end
            if (free_en) begin
                used_q[free_idx] <= 1'b0;
            end
        end
    end

    assign look_tag  = tag_q[look_idx];
    assign look_next = next_q[look_idx];

    AST_NO_ALLOC_FULL: assert property (@(posedge clk) disable iff (rst)
        alloc_en |-> !pool_full); // R7
    AST_ALLOC_FREE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(alloc_en && free_en)); // R6
    AST_FREE_USED: assert property (@(posedge clk) disable iff (rst)
        free_en |-> used_q[free_idx]); // R6

endmodule

// File: rtl/pt_resp_drain.sv
module pt_resp_drain #(
    parameter int unsigned TAG_W  = 4,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned PTR_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              hit_en,
    input  logic [TAG_W-1:0]  hit_tag,
    input  logic [DATA_W-1:0] hit_data,
    input  logic              start_en,
    input  logic [PTR_W-1:0]  start_head,
    input  logic [PTR_W-1:0]  start_tail,
    input  logic [DATA_W-1:0] start_data,
    input  logic [TAG_W-1:0]  node_tag,
    input  logic [PTR_W-1:0]  node_next,
    input  logic              rsp_ready,
    output logic              busy,
    output logic              slot_free,
    output logic              free_en,
    output logic [PTR_W-1:0]  cursor,
    output logic              rsp_valid,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic [DATA_W-1:0] rsp_data
);
    logic              busy_q;
    logic [PTR_W-1:0]  cur_q;
    logic [PTR_W-1:0]  last_q;
    logic [DATA_W-1:0] value_q;
    logic              valid_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] data_q;

    assign slot_free = !valid_q || rsp_ready;
    assign free_en   = busy_q && slot_free;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            busy_q  <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            if (valid_q && rsp_ready) valid_q <= 1'b0;
            if (hit_en) begin
                valid_q <= 1'b1;
                tag_q   <= hit_tag;
                data_q  <= hit_data;
            end
            if (start_en) begin
                busy_q  <= 1'b1;
                cur_q   <= start_head;
                last_q  <= start_tail;
                value_q <= start_data;
            end else if (free_en) begin
                valid_q <= 1'b1;
                tag_q   <= node_tag;
                data_q  <= value_q;
                cur_q   <= node_next;
                if (cur_q == last_q) busy_q <= 1'b0;
            end
        end
    end

    assign busy      = busy_q;
    assign cursor    = cur_q;
    assign rsp_valid = valid_q;
    assign rsp_tag   = tag_q;
    assign rsp_data  = data_q;

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !rsp_ready && !clr) |=> (valid_q && $stable(tag_q) && $stable(data_q))); // R8
    AST_DRAIN_ISSUE: assert property (@(posedge clk) disable iff (rst)
        (busy_q && slot_free && !clr) |=> valid_q); // R6
    AST_NO_HIT_IN_DRAIN: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> !hit_en); // R6

endmodule

// File: rtl/pt_presence_mem.sv
module pt_presence_mem
    import pt_mem_pkg::*;
#(
    parameter int unsigned ADDR_W     = DEF_ADDR_W,
    parameter int unsigned DATA_W     = DEF_DATA_W,
    parameter int unsigned TAG_W      = DEF_TAG_W,
    parameter int unsigned POOL_DEPTH = DEF_POOL_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_dup_err,
    input  logic              rd_valid,
    output logic              rd_ready,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic [DATA_W-1:0] rsp_data
);
    localparam int unsigned PTR_W = (POOL_DEPTH > 1) ? $clog2(POOL_DEPTH) : 1;

    logic              rd_present, rd_waiting, wr_present, wr_waiting;
    logic [DATA_W-1:0] rd_value;
    logic [PTR_W-1:0]  rd_tail, wr_head, wr_tail;
    logic [PTR_W-1:0]  alloc_idx, cursor, look_next;
    logic [TAG_W-1:0]  look_tag;
    logic              pool_full, busy, slot_free, free_en;
    logic              wr_fire, rd_fire, dup_q;
    wr_kind_e          wkind;
    rd_kind_e          rkind;

    assign wr_ready = !busy && !clr;
    assign rd_ready = !busy && !clr && !pool_full && slot_free && !wr_valid;
    assign wr_fire  = wr_valid && wr_ready;
    assign rd_fire  = rd_valid && rd_ready;
    assign wkind    = classify_write(wr_fire, wr_present, wr_waiting);
    assign rkind    = classify_read(rd_fire, rd_present);

    pt_word_table #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_words (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .fill_en    (wkind == WR_FILL || wkind == WR_WAKE),
        .fill_addr  (wr_addr),
        .fill_data  (wr_data),
        .app_en     (rkind == RD_PARK),
        .app_addr   (rd_addr),
        .app_node   (alloc_idx),
        .rd_addr    (rd_addr),
        .wr_addr    (wr_addr),
        .rd_present (rd_present),
        .rd_value   (rd_value),
        .rd_waiting (rd_waiting),
        .rd_tail    (rd_tail),
        .wr_present (wr_present),
        .wr_waiting (wr_waiting),
        .wr_head    (wr_head),
        .wr_tail    (wr_tail)
    );

    pt_defer_pool #(.TAG_W(TAG_W), .DEPTH(POOL_DEPTH), .PTR_W(PTR_W)) u_pool (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .alloc_en  (rkind == RD_PARK),
        .alloc_tag (rd_tag),
        .alloc_idx (alloc_idx),
        .pool_full (pool_full),
        .link_en   (rkind == RD_PARK && rd_waiting),
        .link_prev (rd_tail),
        .free_en   (free_en),
        .free_idx  (cursor),
        .look_idx  (cursor),
        .look_tag  (look_tag),
        .look_next (look_next)
    );

    pt_resp_drain #(.TAG_W(TAG_W), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_drain (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .hit_en     (rkind == RD_HIT),
        .hit_tag    (rd_tag),
        .hit_data   (rd_value),
        .start_en   (wkind == WR_WAKE),
        .start_head (wr_head),
        .start_tail (wr_tail),
        .start_data (wr_data),
        .node_tag   (look_tag),
        .node_next  (look_next),
        .rsp_ready  (rsp_ready),
        .busy       (busy),
        .slot_free  (slot_free),
        .free_en    (free_en),
        .cursor     (cursor),
        .rsp_valid  (rsp_valid),
        .rsp_tag    (rsp_tag),
        .rsp_data   (rsp_data)
    );

    always_ff @(posedge clk) begin
        if (rst || clr) dup_q <= 1'b0;
        else            dup_q <= (wkind == WR_DUP);
    end
    assign wr_dup_err = dup_q;

    AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst || clr)
        (rd_fire && rd_present) |=> (rsp_valid && rsp_tag == $past(rd_tag) && rsp_data == $past(rd_value))); // R4
    AST_DUP_FLAG: assert property (@(posedge clk) disable iff (rst || clr)
        (wr_fire && wr_present) |=> wr_dup_err); // R5
    AST_DUP_ONLY_ON_FULL: assert property (@(posedge clk) disable iff (rst)
        wr_dup_err |-> $past(wr_fire && wr_present)); // R5
    AST_PARK_SILENT: assert property (@(posedge clk) disable iff (rst)
        (rd_fire && !rd_present && !busy && !clr) |=> !busy); // R3

endmodule

// File: tb/pt_presence_mem_tb.sv
module pt_presence_mem_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int POOL = 8;

    logic        clk = 1'b0;
    logic        rst, clr;
    logic        wr_valid, wr_ready, wr_dup_err;
    logic [3:0]  wr_addr;
    logic [15:0] wr_data;
    logic        rd_valid, rd_ready;
    logic [3:0]  rd_addr, rd_tag;
    logic        rsp_valid, rsp_ready;
    logic [3:0]  rsp_tag;
    logic [15:0] rsp_data;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pt_presence_mem dut_i (
        .clk(clk), .rst(rst), .clr(clr),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_dup_err(wr_dup_err),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_tag(rd_tag),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_tag(rsp_tag), .rsp_data(rsp_data)
    );

    int checks = 0;
    int errors = 0;
    int tcount = 0;
    int n_log  = 0;
    bit finished = 0;
    logic acc_rd, acc_wr;
    logic [3:0]  log_tag  [128];
    logic [15:0] log_data [128];
    int          log_t    [128];

    // op: 0 write, 1 read ; addr ; value (tag in low bits for reads)
    localparam int NOPS = 9;
    localparam logic [21:0] OPS [NOPS] = '{
        {2'd1, 4'd3, 16'h0001},
        {2'd1, 4'd3, 16'h0002},
        {2'd1, 4'd5, 16'h0003},
        {2'd0, 4'd5, 16'h1111},
        {2'd0, 4'd3, 16'hBEEF},
        {2'd1, 4'd3, 16'h0004},
        {2'd0, 4'd7, 16'h0042},
        {2'd1, 4'd7, 16'h0005},
        {2'd1, 4'd9, 16'h0006}
    };
    localparam int NEXP = 5;
    localparam logic [19:0] EXP [NEXP] = '{
        {4'd3, 16'h1111},
        {4'd1, 16'hBEEF},
        {4'd2, 16'hBEEF},
        {4'd4, 16'hBEEF},
        {4'd5, 16'h0042}
    };

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        acc_rd = rd_valid && rd_ready;
        acc_wr = wr_valid && wr_ready;
        if (rsp_valid && rsp_ready && n_log < 128) begin
            log_tag[n_log]  = rsp_tag;
            log_data[n_log] = rsp_data;
            log_t[n_log]    = tcount;
            n_log++;
        end
        @(posedge clk);
        #1;
        tcount++;
    endtask

    task automatic do_write(input logic [3:0] a, input logic [15:0] d);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        do tick(); while (!acc_wr);
        wr_valid = 1'b0;
    endtask

    task automatic do_read(input logic [3:0] a, input logic [3:0] t, output int at);
        rd_valid = 1'b1; rd_addr = a; rd_tag = t;
        do begin
            at = tcount;
            tick();
        end while (!acc_rd);
        rd_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R6 watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int at, n0, hits;
        rst = 1'b1; clr = 1'b0; wr_valid = 1'b0; rd_valid = 1'b0; rsp_ready = 1'b1;
        wr_addr = '0; wr_data = '0; rd_addr = '0; rd_tag = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #1;
        // R1 reset state
        check("R1", rsp_valid, 0, "rsp_valid after reset");
        check("R1", wr_ready, 1, "wr_ready after reset");
        check("R1", rd_ready, 1, "rd_ready after reset");
        check("R1", wr_dup_err, 0, "wr_dup_err after reset");

        // Table walk: R2 R3 R6 R9
        n0 = n_log;
        for (int k = 0; k < NOPS; k++) begin
            if (OPS[k][21:20] == 2'd0) do_write(OPS[k][19:16], OPS[k][15:0]);
            else begin
                do_read(OPS[k][19:16], OPS[k][3:0], at);
                if (k < 3) begin
                    idle(3);
                    check("R3", n_log - n0, 0, "response before write to parked word");
                end
            end
        end
        idle(6);
        check("R9", n_log - n0, NEXP, "response count (tag 6 stays parked)");
        for (int k = 0; k < NEXP; k++) begin
            check("R6", log_tag[n0 + k], EXP[k][19:16], $sformatf("tag of response %0d", k));
            check("R2", log_data[n0 + k], EXP[k][15:0], $sformatf("data of response %0d", k));
        end

        // R4 one-cycle latency on a present word
        n0 = n_log;
        do_read(4'd7, 4'd12, at);
        idle(2);
        check("R4", n_log - n0, 1, "hit response count");
        check("R4", log_t[n0] - at, 1, "hit latency in cycles");
        check("R4", log_data[n0], 16'h0042, "hit data");

        // R5 duplicate write
        do_write(4'd7, 16'h9999);
        check("R5", wr_dup_err, 1, "dup flag after second write");
        tick();
        check("R5", wr_dup_err, 0, "dup flag one cycle only");
        n0 = n_log;
        do_read(4'd7, 4'd13, at);
        idle(2);
        check("R5", log_data[n0], 16'h0042, "data after duplicate write");

        // R10 write priority
        wr_valid = 1'b1; wr_addr = 4'd11; wr_data = 16'h0; rd_valid = 1'b1; rd_addr = 4'd7;
        #1;
        check("R10", rd_ready, 0, "rd_ready with wr_valid high");
        wr_valid = 1'b0; rd_valid = 1'b0;

        // R1 clear
        clr = 1'b1; tick(); clr = 1'b0;
        check("R1", rsp_valid, 0, "rsp_valid after clear");
        n0 = n_log;
        do_read(4'd3, 4'd10, at);
        idle(4);
        check("R1", n_log - n0, 0, "read of cleared word answered");

        // R7 pool full, then drain R6
        clr = 1'b1; tick(); clr = 1'b0;
        for (int k = 0; k < POOL; k++) do_read(4'd2, 4'(k), at);
        rd_valid = 1'b1; rd_addr = 4'd2; rd_tag = 4'd15;
        #1;
        check("R7", rd_ready, 0, "rd_ready with pool full");
        rd_valid = 1'b0;
        n0 = n_log;
        do_write(4'd2, 16'h2222);
        check("R6", wr_ready, 0, "wr_ready while draining");
        check("R6", rd_ready, 0, "rd_ready while draining");
        idle(POOL + 4);
        check("R6", n_log - n0, POOL, "drained response count");
        for (int k = 0; k < POOL; k++) begin
            check("R6", log_tag[n0 + k], k, $sformatf("drain order %0d", k));
            if (k > 0) check("R6", log_t[n0 + k] - log_t[n0 + k - 1], 1, "one response per cycle");
        end
        check("R7", rd_ready, 1, "rd_ready after drain");

        // R8 hold under backpressure
        do_write(4'd4, 16'h4444);
        rsp_ready = 1'b0;
        do_read(4'd4, 4'd11, at);
        for (int k = 0; k < 3; k++) begin
            tick();
            check("R8", rsp_valid, 1, "rsp_valid held");
            check("R8", rsp_tag, 11, "rsp_tag held");
            check("R8", rsp_data, 16'h4444, "rsp_data held");
        end
        n0 = n_log;
        rsp_ready = 1'b1;
        idle(3);
        hits = 0;
        for (int k = n0; k < n_log; k++) if (log_tag[k] == 4'd11) hits++;
        check("R8", hits, 1, "held response delivered once");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule